// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses which of four candidate clocks drives the root of a clock tree and derives three slower clock domains from that root. Every clock is modelled as a one-cycle enable pulse in a single fast clock domain. The input clock arrives on `in_ce`. The PLL output arrives on `pll_ce`, and an alternate clock arrives on `alt_ce`. The PLL itself is outside the block and is represented only by its lock input. The block does no analog switching.

Software programs four registers over a simple synchronous bus. Writes take effect on the clock edge on which they are sampled. Reads are combinational.

- The flag register (address 0) holds:
  - the input-halving bit,
  - the bit that allows the full-rate input,
  - the PLL pick bit,
  - a read-only lock bit,
  - a read-only source status field.
- The control register (address 1) holds the alternate-clock select.
- The PLL register (address 2) holds the divider code, the multiplier code and the reference-range bit.
- The prescale register (address 3) holds the three domain division codes.

The selected source is found by a fixed-priority decode across the flag and control registers. A switch to the PLL is held off until the PLL reports lock. Lock is never reported while the PLL is powered down.

Top module: `sysclk_src_ctrl`

## Requirements
- R1: After reset, the registers hold the following values, and the source status reads 01 (input divided by 16).
  - Flag register: all writable bits are 0.
  - Control register: 0.
  - PLL register: divider code 111 (PLL off), multiplier code 00, range bit 0.
  - Prescale register: all codes 00 (divide by 1).
- R2: The requested source follows a fixed priority:
  - If control bit 2 (alternate select) is set, the alternate clock is requested.
  - Otherwise, if flag bit 1 (full-rate allow) is 0, the input divided by 16 is requested.
  - Otherwise, if flag bit 2 (PLL pick) is set, the PLL is requested.
  - Otherwise, the raw input is requested.

  The active source takes the requested value one cycle after the register write, unless the PLL gate of R5 holds it. `root_ce` then reproduces the enable pulses of the active source.
- R3: The active source reads back on flag bits [5:4] and on `src_status`. The codes are 00 for the PLL, 01 for the input divided by 16, 10 for the raw input and 11 for the alternate clock.
- R4: `lock_flag` and flag bit 3 equal `pll_locked`, forced to 0 while the PLL divider code (PLL register bits [2:0]) is 111. `pll_off` is high exactly while that code is 111.
- R5: While lock is reported low, a request for the PLL leaves the previous source active. The PLL becomes active on the first clock edge at which the reported lock is high.
- R6: When flag bit 0 (halve) is set, only every other `in_ce` pulse is passed on to the input paths. The raw-input and divide-by-16 sources therefore run at half rate.
- R7: The divide-by-16 source emits one pulse for every 16 pulses of the possibly halved input.
- R8: Each derived domain pulses once per 2^code pulses of `root_ce`, and each of its pulses coincides with a `root_ce` pulse. The codes sit in the prescale register: main domain at bits [1:0], peripheral 1 at bits [3:2], peripheral 2 at bits [5:4].
- R9: A new prescale code is taken up only when the domain's divider wraps, so one pulse at the old spacing always completes first.
- R10: The PLL register is exposed on the outputs:
  - divider code on `pll_div_code`,
  - multiplier code (bits [5:4]) on `pll_mult` as 12, 16, 20 or 24,
  - range bit (bit 7) on `pll_fref_hi`.
- R11: Read-only and unmapped bits read 0 (except the status and lock fields) and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| in_ce | input | 1 | Input clock enable pulse |
| pll_ce | input | 1 | PLL output enable pulse |
| alt_ce | input | 1 | Alternate clock enable pulse |
| pll_locked | input | 1 | Lock indication from the PLL |
| root_ce | output | 1 | Root clock enable pulse |
| main_ce | output | 1 | Main domain enable pulse |
| per1_ce | output | 1 | Peripheral domain 1 enable pulse |
| per2_ce | output | 1 | Peripheral domain 2 enable pulse |
| src_status | output | 2 | Active source code |
| lock_flag | output | 1 | Reported PLL lock |
| pll_div_code | output | 3 | PLL divider code |
| pll_mult | output | 5 | PLL multiplication factor |
| pll_fref_hi | output | 1 | PLL reference-range bit |
| pll_off | output | 1 | PLL powered down |

## Verification
The bench raises the PLL lock input while the divider code is 111. A design that passes lock straight through would report lock and could switch to a PLL that is not running.

It requests the PLL with lock low and then raises lock. A design that switches at once, or one cycle late, shows a wrong status code on the cycles it checks.

It rewrites the prescale codes while the dividers are running and walks through every overlap of the select bits. A design that reloads the divider at once would lose the pulse that finishes at the old spacing. One that orders the select bits wrongly reports the wrong source.

A cycle-by-cycle bench model runs alongside random pulse patterns and random register writes. Errors in halving phase, divide-by-16 phase or prescaler spacing show up as pulses on the wrong cycle.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
   typedef enum logic [1:0] {
      SRC_PLL  = 2'b00,
      SRC_IN16 = 2'b01,
      SRC_RAW  = 2'b10,
      SRC_ALT  = 2'b11
   } src_e;

   localparam logic [1:0] ADR_FLAG = 2'd0;
   localparam logic [1:0] ADR_CTRL = 2'd1;
   localparam logic [1:0] ADR_PLL  = 2'd2;
   localparam logic [1:0] ADR_PRE  = 2'd3;

   localparam logic [2:0] PLL_OFF_CODE = 3'b111;

   function automatic logic [4:0] mult_value(input logic [1:0] code);
      return 5'd12 + {1'b0, code, 2'b00};
   endfunction
endpackage

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs
   import sysclk_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PRE_W  = 2,
   parameter int unsigned N_DOM  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_i,
   input  logic                     we_i,
   input  logic [1:0]               addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        rdata_o,
   input  logic                     lock_ok_i,
   input  src_e                     act_src_i,
   output logic                     div2_o,
   output logic                     full_rate_o,
   output logic                     pll_pick_o,
   output logic                     alt_sel_o,
   output logic [2:0]               pll_div_o,
   output logic [1:0]               pll_mul_o,
   output logic                     fref_hi_o,
   output logic [N_DOM*PRE_W-1:0]   pre_o
);
   localparam int unsigned PRE_BITS = N_DOM * PRE_W;

   generate
      if (DATA_W < 8 || PRE_BITS > DATA_W) begin : g_bad_width
         $error("sysclk_regs: DATA_W too small for the register fields");
      end
   endgenerate

   logic wr;
   assign wr = sel_i & we_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div2_o      <= 1'b0;
         full_rate_o <= 1'b0;
         pll_pick_o  <= 1'b0;
         alt_sel_o   <= 1'b0;
         pll_div_o   <= PLL_OFF_CODE;
         pll_mul_o   <= 2'b00;
         fref_hi_o   <= 1'b0;
         pre_o       <= '0;
      end else if (wr) begin
         unique case (addr_i)
            ADR_FLAG: begin
               div2_o      <= wdata_i[0];
               full_rate_o <= wdata_i[1];
               pll_pick_o  <= wdata_i[2];
            end
            ADR_CTRL: alt_sel_o <= wdata_i[2];
            ADR_PLL: begin
               pll_div_o <= wdata_i[2:0];
               pll_mul_o <= wdata_i[5:4];
               fref_hi_o <= wdata_i[7];
            end
            ADR_PRE: pre_o <= wdata_i[PRE_BITS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         ADR_FLAG: begin
            rdata_o[0]   = div2_o;
            rdata_o[1]   = full_rate_o;
            rdata_o[2]   = pll_pick_o;
            rdata_o[3]   = lock_ok_i;
            rdata_o[5:4] = act_src_i;
         end
         ADR_CTRL: rdata_o[2] = alt_sel_o;
         ADR_PLL: begin
            rdata_o[2:0] = pll_div_o;
            rdata_o[5:4] = pll_mul_o;
            rdata_o[7]   = fref_hi_o;
         end
         ADR_PRE: rdata_o[PRE_BITS-1:0] = pre_o;
         default: ;
      endcase
   end

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_i == ADR_CTRL) |=> (alt_sel_o == $past(wdata_i[2])));
endmodule

// File: rtl/sysclk_src_sel.sv
`timescale 1ns/1ps
module sysclk_src_sel
   import sysclk_pkg::*;
#(
   parameter int unsigned IN_DIV   = 16,
   parameter bit          HAS_DIV2 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       div2_i,
   input  logic       full_rate_i,
   input  logic       pll_pick_i,
   input  logic       alt_sel_i,
   input  logic [2:0] pll_div_i,
   input  logic       pll_locked_i,
   input  logic       in_ce_i,
   input  logic       pll_ce_i,
   input  logic       alt_ce_i,
   output logic       root_ce_o,
   output logic       lock_ok_o,
   output src_e       act_src_o
);
   localparam int unsigned CNT_W = $clog2(IN_DIV);

   generate
      if (IN_DIV < 2 || (IN_DIV & (IN_DIV - 1)) != 0) begin : g_bad_div
         $error("sysclk_src_sel: IN_DIV must be a power of two of at least 2");
      end
   endgenerate

   logic in_h;

   generate
      if (HAS_DIV2) begin : g_half
         logic half_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !div2_i) half_q <= 1'b0;
            else if (in_ce_i)      half_q <= ~half_q;
         end
         assign in_h = in_ce_i & ~(div2_i & half_q);

         assert_half_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (div2_i && in_h) |=> (!in_h || !div2_i));
      end else begin : g_nohalf
         assign in_h = in_ce_i;
      end
   endgenerate

   logic [CNT_W-1:0] sub_q;
   logic             in16;

   always_ff @(posedge clk) begin
      if (!rst_n)    sub_q <= '0;
      else if (in_h) sub_q <= sub_q + 1'b1;
   end
   assign in16 = in_h & (sub_q == '1);

   assign lock_ok_o = pll_locked_i & (pll_div_i != PLL_OFF_CODE);

   src_e req;
   always_comb begin
      if (alt_sel_i)        req = SRC_ALT;
      else if (!full_rate_i) req = SRC_IN16;
      else if (pll_pick_i)  req = SRC_PLL;
      else                  req = SRC_RAW;
   end

   src_e act_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                           act_q <= SRC_IN16;
      else if (req != SRC_PLL || lock_ok_o) act_q <= req;
   end
   assign act_src_o = act_q;

   always_comb begin
      unique case (act_q)
         SRC_PLL:  root_ce_o = pll_ce_i;
         SRC_IN16: root_ce_o = in16;
         SRC_RAW:  root_ce_o = in_h;
         SRC_ALT:  root_ce_o = alt_ce_i;
         default:  root_ce_o = 1'b0;
      endcase
   end

   assert_pll_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == SRC_PLL && $past(act_q) != SRC_PLL) |-> $past(lock_ok_o));
   assert_alt_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alt_sel_i |=> (act_q == SRC_ALT));
   assert_in16_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in16 |-> in_h);
endmodule

// File: rtl/sysclk_prescaler.sv
`timescale 1ns/1ps
module sysclk_prescaler #(
   parameter int unsigned PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             root_ce_i,
   input  logic [PRE_W-1:0] code_i,
   output logic             tick_o
);
   localparam int unsigned CNT_W = (1 << PRE_W) - 1;

   generate
      if (PRE_W < 1 || PRE_W > 3) begin : g_bad_pre
         $error("sysclk_prescaler: PRE_W must lie in 1..3");
      end
   endgenerate

   logic [PRE_W-1:0] cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic             wrap;

   assign lim  = ~({CNT_W{1'b1}} << cur_q);
   assign wrap = (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cur_q <= '0;
      end else if (root_ce_i) begin
         if (wrap) begin
            cnt_q <= '0;
            cur_q <= code_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign tick_o = root_ce_i & wrap;

   assert_tick_on_root_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> root_ce_i);
   assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_o |=> $stable(cur_q));
endmodule

// File: rtl/sysclk_src_ctrl.sv
`timescale 1ns/1ps
module sysclk_src_ctrl
   import sysclk_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PRE_W    = 2,
   parameter int unsigned IN_DIV   = 16,
   parameter bit          HAS_DIV2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              in_ce,
   input  logic              pll_ce,
   input  logic              alt_ce,
   input  logic              pll_locked,
   output logic              root_ce,
   output logic              main_ce,
   output logic              per1_ce,
   output logic              per2_ce,
   output logic [1:0]        src_status,
   output logic              lock_flag,
   output logic [2:0]        pll_div_code,
   output logic [4:0]        pll_mult,
   output logic              pll_fref_hi,
   output logic              pll_off
);
   localparam int unsigned N_DOM = 3;

   logic                   div2, full_rate, pll_pick, alt_sel, lock_ok;
   logic [2:0]             pll_div;
   logic [1:0]             pll_mul;
   logic [N_DOM*PRE_W-1:0] pre;
   logic [N_DOM-1:0]       tick;
   src_e                   act_src;

   sysclk_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .N_DOM(N_DOM)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .we_i(bus_we),
      .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
      .lock_ok_i(lock_ok), .act_src_i(act_src),
      .div2_o(div2), .full_rate_o(full_rate), .pll_pick_o(pll_pick),
      .alt_sel_o(alt_sel), .pll_div_o(pll_div), .pll_mul_o(pll_mul),
      .fref_hi_o(pll_fref_hi), .pre_o(pre)
   );

   sysclk_src_sel #(.IN_DIV(IN_DIV), .HAS_DIV2(HAS_DIV2)) u_sel (
      .clk(clk), .rst_n(rst_n), .div2_i(div2), .full_rate_i(full_rate),
      .pll_pick_i(pll_pick), .alt_sel_i(alt_sel), .pll_div_i(pll_div),
      .pll_locked_i(pll_locked), .in_ce_i(in_ce), .pll_ce_i(pll_ce),
      .alt_ce_i(alt_ce), .root_ce_o(root_ce), .lock_ok_o(lock_ok),
      .act_src_o(act_src)
   );

   generate
      for (genvar d = 0; d < N_DOM; d++) begin : g_dom
         sysclk_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .root_ce_i(root_ce),
            .code_i(pre[d*PRE_W +: PRE_W]), .tick_o(tick[d])
         );
      end
   endgenerate

   assign main_ce      = tick[0];
   assign per1_ce      = tick[1];
   assign per2_ce      = tick[2];
   assign src_status   = act_src;
   assign lock_flag    = lock_ok;
   assign pll_div_code = pll_div;
   assign pll_mult     = mult_value(pll_mul);
   assign pll_off      = (pll_div == PLL_OFF_CODE);

   assert_off_blocks_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pll_off |-> !lock_flag);
   assert_status_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(src_status));
endmodule

// File: tb/tb_sysclk_src_ctrl.sv
`timescale 1ns/1ps
module tb_sysclk_src_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          in_ce = 1'b0, pll_ce = 1'b0, alt_ce = 1'b0, pll_locked = 1'b0;
   logic          root_ce, main_ce, per1_ce, per2_ce, lock_flag, pll_fref_hi, pll_off;
   logic [1:0]    src_status;
   logic [2:0]    pll_div_code;
   logic [4:0]    pll_mult;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysclk_src_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .in_ce(in_ce), .pll_ce(pll_ce), .alt_ce(alt_ce), .pll_locked(pll_locked),
      .root_ce(root_ce), .main_ce(main_ce), .per1_ce(per1_ce), .per2_ce(per2_ce),
      .src_status(src_status), .lock_flag(lock_flag), .pll_div_code(pll_div_code),
      .pll_mult(pll_mult), .pll_fref_hi(pll_fref_hi), .pll_off(pll_off)
   );

   // ---------------- bench model built from the requirements ----------------
   logic       m_div2, m_full, m_pick, m_alt, m_fhi, m_h;
   logic [2:0] m_pdiv;
   logic [1:0] m_pmul, m_act;
   logic [5:0] m_pre;
   logic [3:0] m_c16;
   logic [2:0] m_pc [3];
   logic [1:0] m_cur [3];

   function automatic logic [2:0] lim_of(input logic [1:0] c);
      return 3'((1 << c) - 1);
   endfunction

   function automatic logic [1:0] req_of(input logic alt, input logic full, input logic pick);
      if (alt) return 2'b11;
      if (!full) return 2'b01;
      if (pick) return 2'b00;
      return 2'b10;
   endfunction

   logic e_lock, e_inh, e_d16, e_root;
   logic [2:0] e_tick;
   always_comb begin
      e_lock = pll_locked && (m_pdiv != 3'b111);
      e_inh  = in_ce && !(m_div2 && m_h);
      e_d16  = e_inh && (m_c16 == 4'hF);
      case (m_act)
         2'b00:   e_root = pll_ce;
         2'b01:   e_root = e_d16;
         2'b10:   e_root = e_inh;
         default: e_root = alt_ce;
      endcase
      for (int k = 0; k < 3; k++) e_tick[k] = e_root && (m_pc[k] == lim_of(m_cur[k]));
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_div2 <= 0; m_full <= 0; m_pick <= 0; m_alt <= 0; m_fhi <= 0; m_h <= 0;
         m_pdiv <= 3'b111; m_pmul <= 0; m_act <= 2'b01; m_pre <= 0; m_c16 <= 0;
         for (int k = 0; k < 3; k++) begin m_pc[k] <= 0; m_cur[k] <= 0; end
      end else begin
         if (bus_sel && bus_we) begin
            case (bus_addr)
               2'd0: begin m_div2 <= bus_wdata[0]; m_full <= bus_wdata[1]; m_pick <= bus_wdata[2]; end
               2'd1: m_alt <= bus_wdata[2];
               2'd2: begin m_pdiv <= bus_wdata[2:0]; m_pmul <= bus_wdata[5:4]; m_fhi <= bus_wdata[7]; end
               default: m_pre <= bus_wdata[5:0];
            endcase
         end
         if (!m_div2) m_h <= 0; else if (in_ce) m_h <= !m_h;
         if (e_inh) m_c16 <= m_c16 + 4'd1;
         if (req_of(m_alt, m_full, m_pick) != 2'b00 || e_lock) m_act <= req_of(m_alt, m_full, m_pick);
         for (int k = 0; k < 3; k++) begin
            if (e_root) begin
               if (m_pc[k] == lim_of(m_cur[k])) begin
                  m_pc[k] <= 0; m_cur[k] <= m_pre[2*k +: 2];
               end else m_pc[k] <= m_pc[k] + 3'd1;
            end
         end
      end
   end

   // lockstep comparison, away from the active edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         checks++;
         if ({root_ce, main_ce, per1_ce, per2_ce} !== {e_root, e_tick[0], e_tick[1], e_tick[2]}) begin
            errors++;
            $display("FAIL R2/R6/R7/R8/R9 pulses: got %b expected %b at cycle %0d",
                     {root_ce, main_ce, per1_ce, per2_ce}, {e_root, e_tick[0], e_tick[1], e_tick[2]}, cyc);
         end
         checks++;
         if (src_status !== m_act || lock_flag !== e_lock) begin
            errors++;
            $display("FAIL R3/R4/R5 status,lock: got %b,%b expected %b,%b at cycle %0d",
                     src_status, lock_flag, m_act, e_lock, cyc);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic after_edge();
      @(posedge clk); #2;
   endtask

   task automatic count_pulses(input int n, output int r, output int m, output int p1, output int p2);
      r = 0; m = 0; p1 = 0; p2 = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         r += int'(root_ce); m += int'(main_ce); p1 += int'(per1_ce); p2 += int'(per2_ce);
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd;
      int r, m, p1, p2;
      void'($urandom(32'h5EED_0C1C));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1 reset state
      bus_read(2'd0, rd); check("R1 flag reg", rd, 16'h0010);
      bus_read(2'd1, rd); check("R1 ctrl reg", rd, 16'h0000);
      bus_read(2'd2, rd); check("R1 pll reg", rd, 16'h0007);
      bus_read(2'd3, rd); check("R1 prescale reg", rd, 16'h0000);
      check("R1 status", src_status, 2'b01);
      check("R1 pll_off", pll_off, 1);

      // R4 lock masked while powered down
      @(negedge clk) pll_locked = 1;
      #1 check("R4 lock masked when off", lock_flag, 0);
      bus_write(2'd2, 16'h00B3);
      check("R4 lock when running", lock_flag, 1);
      check("R4 pll_off clear", pll_off, 0);
      check("R10 mult 24", pll_mult, 24);
      check("R10 div code", pll_div_code, 3);
      check("R10 range bit", pll_fref_hi, 1);
      bus_read(2'd2, rd); check("R10 pll readback", rd, 16'h00B3);
      bus_read(2'd0, rd); check("R4 lock bit read", rd, 16'h0018);

      // R11 read-only and unmapped bits
      bus_write(2'd0, 16'hFFF8);
      bus_read(2'd0, rd); check("R11 flag ro bits", rd, 16'h0018);
      bus_write(2'd1, 16'hFFFB);
      bus_read(2'd1, rd); check("R11 ctrl unmapped", rd, 16'h0000);

      // R5 PLL switch waits for lock
      @(negedge clk) pll_locked = 0;
      bus_write(2'd0, 16'h0006);
      repeat (3) after_edge();
      check("R5 held without lock", src_status, 2'b01);
      @(negedge clk) pll_locked = 1;
      #1 check("R5 not yet switched", src_status, 2'b01);
      after_edge();
      check("R5 switched after lock", src_status, 2'b00);

      // R2 priority decode, R3 codes
      bus_write(2'd1, 16'h0004); after_edge();
      check("R2 alt wins over pll", src_status, 2'b11);
      bus_write(2'd0, 16'h0000); after_edge();
      check("R2 alt wins over div16", src_status, 2'b11);
      bus_write(2'd1, 16'h0000); after_edge();
      check("R3 div16 code", src_status, 2'b01);
      bus_write(2'd0, 16'h0002); after_edge();
      check("R3 raw code", src_status, 2'b10);
      bus_write(2'd0, 16'h0006); after_edge();
      check("R2 pll chosen when locked", src_status, 2'b00);
      bus_write(2'd2, 16'h0007);
      check("R4 lock dropped when off", lock_flag, 0);

      // R8 / R9 prescaler spacing on the raw input
      bus_write(2'd0, 16'h0002);
      @(negedge clk) in_ce = 1;
      count_pulses(32, r, m, p1, p2);
      check("R2 raw root count", r, 32);
      check("R8 div1 main count", m, 32);
      bus_write(2'd3, 16'h0027);
      count_pulses(64, r, m, p1, p2);
      check("R9 main div8 with deferred load", m, 8);
      check("R9 per1 div2 with deferred load", p1, 32);
      check("R9 per2 div4 with deferred load", p2, 16);

      // R6 halving
      bus_write(2'd0, 16'h0003);
      count_pulses(32, r, m, p1, p2);
      check("R6 halved root count", r, 16);

      // R7 divide by 16
      bus_write(2'd0, 16'h0000);
      count_pulses(64, r, m, p1, p2);
      check("R7 div16 root count", r, 4);

      // random phase, checked by the lockstep model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         in_ce  = 1'($urandom);
         pll_ce = 1'($urandom);
         alt_ce = 1'($urandom);
         if ($urandom % 50 == 0) pll_locked = ~pll_locked;
         if ($urandom % 16 == 0) begin
            bus_sel = 1; bus_we = 1;
            bus_addr = 2'($urandom);
            bus_wdata = 16'($urandom);
         end else begin
            bus_sel = 0; bus_we = 0;
         end
      end
      @(negedge clk) begin bus_sel = 0; bus_we = 0; end
      repeat (2) @(posedge clk);

      #3 done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule